// File: doc/BRIEF.md
# Two-Wire Delta-Sigma Converter Reader

This block is the host side of a serial link to a delta-sigma converter that uses only two wires: a serial clock that the host drives, and a single return line. The converter uses that line for two jobs. When it is held low, it says a conversion result is waiting. During a read, it carries the result bits. The reader is armed by a start request. It watches the synchronized line for the ready level and then generates the serial clock. It captures one bit per pulse, most significant first, and delivers an 18-bit signed sample on a parallel output with a one-cycle strobe.

Each read frame carries 24 data pulses. The host picks a frame mode when it issues the start request, and the mode sets how the frame ends. A plain read stops after the data, and the line then keeps the last bit. A second mode adds one extra pulse, which returns the line to its high idle level. A third mode adds two extra pulses, and the second of these tells the converter to calibrate itself. The serial clock rate comes from a programmable divider of the system clock.

Top module: `adc2w_reader`

## Requirements
- R1: After reset, `sclk` is low, `busy` is low, `sample_valid` is low and `sample` is zero.
- R2: After a start request, the reader produces no `sclk` pulse and keeps `busy` low until the synchronized `rdy_dout` is seen low. `busy` rises only after a low has been sampled.
- R3: `sclk` is high only while `busy` is set, and it starts every frame low. Each high phase and each low phase lasts `max(div, 2) + 1` system clock cycles.
- R4: The number of `sclk` pulses in a frame depends on the `mode` value latched at start. 2'b00 gives 24 pulses, 2'b01 gives 25, 2'b10 gives 26, and 2'b11 gives 24.
- R5: Bits are captured on the falling `sclk` edge, half a period after the rising edge that shifts them out. The first captured bit is the MSB. `sample` is the first 18 of the 24 captured bits, as two's complement, and the 6 trailing bits are dropped. `sample_valid` pulses for exactly one cycle per frame, and `sample` holds its value between pulses.
- R6: `busy` stays high from ready detection until the falling edge of the last pulse. A start request made while a frame is armed or running is ignored: it changes neither the pulse count nor the mode, and it does not start a further frame.
- R7: After a frame ends, a low level on `rdy_dout` is not taken as ready until the line has been seen high at least once.
- R8: A `div` value below 2 is treated as 2. This gives a minimum half period of 3 cycles, so each captured bit has passed through the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to arm one read frame; ignored unless the reader is idle |
| mode | input | 2 | Frame ending: 00 plain, 01 return line high, 10 calibrate, 11 plain |
| div | input | DIV_W | Half-period setting for `sclk`, in system cycles minus one |
| rdy_dout | input | 1 | Shared ready/data line from the converter |
| sclk | output | 1 | Serial clock to the converter |
| sample | output | SAMPLE_W | Signed sample from the last frame |
| sample_valid | output | 1 | One-cycle strobe when `sample` is updated |
| busy | output | 1 | High from ready detection to the end of the last pulse |

## Verification
Most internal faults in this reader show up at the ports within a single frame. If the pulse counter is wrong, the frame has the wrong number of `sclk` rising edges, and `busy` drops early or late. That is visible within about 26 serial periods. If the half-period counter or the divider clamp is wrong, the width of every `sclk` phase changes from the first pulse onward. If the shift or capture point is off by one, the sample comes out shifted by one bit at the `sample_valid` strobe of the very first frame. If the stale-line guard is broken, a frame starts on a low line left over from a plain read, within three cycles of the start request.

// File: rtl/adc2w_reader.sv
module adc2w_reader #(
  parameter int SAMPLE_W     = 18,
  parameter int FRAME_PULSES = 24,
  parameter int DIV_W        = 8,
  parameter int MIN_DIV      = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 mode,
  input  logic [DIV_W-1:0]           div,
  input  logic                       rdy_dout,
  output logic                       sclk,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       sample_valid,
  output logic                       busy
);

  localparam int CNT_W = $clog2(FRAME_PULSES + 3);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} state_t;

  state_t                  state;
  logic [1:0]              sync;
  logic                    stale;
  logic [1:0]              mode_q;
  logic [DIV_W-1:0]        half_q;
  logic [DIV_W-1:0]        hc;
  logic [CNT_W-1:0]        pc;
  logic [FRAME_PULSES-1:0] shreg;

  wire                    line_s   = sync[1];
  wire [DIV_W-1:0]        div_eff  = (div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div;
  wire [CNT_W-1:0]        last_pc  = (mode_q == 2'b01) ? CNT_W'(FRAME_PULSES + 1) :
                                     (mode_q == 2'b10) ? CNT_W'(FRAME_PULSES + 2) :
                                                         CNT_W'(FRAME_PULSES);
  wire                    tick     = (state == S_RUN) && (hc == half_q);
  wire                    rise     = tick && !sclk;
  wire                    fall     = tick && sclk;
  wire [FRAME_PULSES-1:0] sh_next  = {shreg[FRAME_PULSES-2:0], line_s};

  assign busy = (state == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rdy_dout};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      stale        <= 1'b0;
      mode_q       <= 2'b00;
      half_q       <= DIV_W'(MIN_DIV);
      hc           <= '0;
      pc           <= '0;
      shreg        <= '0;
      sclk         <= 1'b0;
      sample       <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (state != S_RUN && line_s) stale <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mode_q <= mode;
          half_q <= div_eff;
          state  <= S_WAIT;
        end
        S_WAIT: if (!line_s && !stale) begin
          state <= S_RUN;
          hc    <= '0;
          pc    <= '0;
          sclk  <= 1'b0;
        end
        S_RUN: begin
          hc <= tick ? '0 : hc + 1'b1;
          if (rise) begin
            sclk <= 1'b1;
            pc   <= pc + 1'b1;
          end
          if (fall) begin
            sclk <= 1'b0;
            if (pc <= CNT_W'(FRAME_PULSES)) shreg <= sh_next;
            if (pc == CNT_W'(FRAME_PULSES)) begin
              sample       <= sh_next[FRAME_PULSES-1 -: SAMPLE_W];
              sample_valid <= 1'b1;
            end
            if (pc == last_pc) begin
              state <= S_IDLE;
              stale <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module adc2w_reader_chk #(
  parameter int SAMPLE_W     = 18,
  parameter int FRAME_PULSES = 24,
  parameter int DIV_W        = 8,
  parameter int MIN_DIV      = 2,
  parameter int CNT_W        = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sclk,
  input logic                busy,
  input logic                sample_valid,
  input logic [SAMPLE_W-1:0] sample,
  input logic                line_s,
  input logic [1:0]          mode_q,
  input logic [DIV_W-1:0]    half_q,
  input logic [DIV_W-1:0]    hc,
  input logic [CNT_W-1:0]    pc
);

  assert_busy_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(line_s));

  assert_sclk_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  assert_frame_starts_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sclk);

  assert_pulse_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= CNT_W'(FRAME_PULSES + 2));

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_sample_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample));

  assert_mode_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

  assert_half_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (half_q >= DIV_W'(MIN_DIV)) && (hc <= half_q));

endmodule

bind adc2w_reader adc2w_reader_chk #(
  .SAMPLE_W(SAMPLE_W), .FRAME_PULSES(FRAME_PULSES), .DIV_W(DIV_W),
  .MIN_DIV(MIN_DIV), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .busy(busy),
  .sample_valid(sample_valid), .sample(sample), .line_s(line_s),
  .mode_q(mode_q), .half_q(half_q), .hc(hc), .pc(pc)
);

// File: tb/adc2w_reader_tb.sv
`timescale 1ns/1ps
module adc2w_reader_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] div = 8'd2;
  logic line = 1'b1;
  logic sclk;
  logic signed [17:0] sample;
  logic sample_valid;
  logic busy;

  always #2.5 clk = ~clk;

  adc2w_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .div(div),
    .rdy_dout(line), .sclk(sclk), .sample(sample),
    .sample_valid(sample_valid), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter stub
  logic [23:0] word = 24'h0;
  int bitk = 0;
  always @(posedge sclk) begin
    bitk = bitk + 1;
    if (bitk <= 24) line = word[24 - bitk];
    else if (bitk == 25) line = 1'b1;
  end

  // pulse and phase measurement
  int pcount = 0;
  int hi = 0;
  int half_err = 0;
  int exp_half = 3;
  always @(posedge sclk) pcount = pcount + 1;
  always @(negedge clk) begin
    if (sclk) hi = hi + 1;
    else if (hi != 0) begin
      if (hi != exp_half) half_err = half_err + 1;
      hi = 0;
    end
  end

  // scoreboard
  logic signed [17:0] expq[$];
  always @(negedge clk) begin
    if (rst_n && sample_valid) begin
      if (expq.size() == 0) chk(1'b0, "R6", "unexpected sample_valid", sample, 0);
      else begin
        logic signed [17:0] e;
        e = expq.pop_front();
        chk(sample === e, "R5", "sample", sample, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R2", "watchdog", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic issue_start(input logic [1:0] m, input logic [7:0] d);
    @(posedge clk); #1;
    start = 1'b1; mode = m; div = d;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic expect_frame(input logic [23:0] w, input logic [7:0] d);
    expq.push_back(w[23:6]);
    pcount = 0; half_err = 0;
    exp_half = ((d < 8'd2) ? 2 : int'(d)) + 1;
  endtask

  task automatic convert(input logic [23:0] w);
    @(posedge clk); #1;
    line = 1'b1; word = w; bitk = 0;
    repeat (6) @(posedge clk);
    #1 line = 1'b0;
  endtask

  task automatic wait_frame(input int exp_pulses, input string req);
    int n;
    n = 0;
    while (!busy && n < 3000) begin @(negedge clk); n++; end
    n = 0;
    while (busy && n < 6000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(pcount == exp_pulses, req, "pulse count", pcount, exp_pulses);
    chk(half_err == 0, "R3", "phase length errors", half_err, 0);
  endtask

  task automatic frame(input logic [1:0] m, input logic [7:0] d,
                       input logic [23:0] w, input int pulses, input string req);
    issue_start(m, d);
    expect_frame(w, d);
    convert(w);
    wait_frame(pulses, req);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(sclk == 1'b0, "R1", "sclk at reset", sclk, 0);
    chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
    chk(sample_valid == 1'b0, "R1", "valid at reset", sample_valid, 0);
    chk(sample == 18'sd0, "R1", "sample at reset", sample, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2: armed but line high -> nothing happens
    issue_start(2'b00, 8'd2);
    pcount = 0;
    repeat (100) @(negedge clk);
    chk(pcount == 0, "R2", "pulses before ready", pcount, 0);
    chk(busy == 1'b0, "R2", "busy before ready", busy, 0);
    expect_frame(24'h7FFFC5, 8'd2);
    convert(24'h7FFFC5);
    wait_frame(24, "R4");

    // modes and dividers
    frame(2'b01, 8'd3, 24'h800021, 25, "R4");
    frame(2'b10, 8'd5, 24'hA5A5A5, 26, "R4");
    frame(2'b11, 8'd0, 24'h123457, 24, "R8");
    frame(2'b00, 8'd1, 24'hFEDCB9, 24, "R8");
    frame(2'b01, 8'd7, 24'h000001, 25, "R5");

    // R7: plain read leaving line low (last bit 0)
    frame(2'b00, 8'd2, 24'h3C3C00, 24, "R7");
    issue_start(2'b00, 8'd2);
    pcount = 0;
    repeat (80) @(negedge clk);
    chk(busy == 1'b0, "R7", "frame on stale low line", busy, 0);
    chk(pcount == 0, "R7", "pulses on stale low line", pcount, 0);
    expect_frame(24'h5A5A5B, 8'd2);
    convert(24'h5A5A5B);
    wait_frame(24, "R7");

    // R6: start while busy is ignored
    issue_start(2'b00, 8'd3);
    expect_frame(24'hC0FFEE, 8'd3);
    convert(24'hC0FFEE);
    while (!busy) @(negedge clk);
    repeat (10) @(negedge clk);
    issue_start(2'b10, 8'd2);
    wait_frame(24, "R6");
    convert(24'h0F0F0F);
    pcount = 0;
    repeat (150) @(negedge clk);
    chk(busy == 1'b0, "R6", "frame from ignored start", busy, 0);
    chk(pcount == 0, "R6", "pulses from ignored start", pcount, 0);
    issue_start(2'b01, 8'd2);
    expect_frame(24'h0F0F0F, 8'd2);
    wait_frame(25, "R6");

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R5", "samples outstanding", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule